// File: doc/BRIEF.md
# Instruction Byte Prefetch Unit

This block sits on the bus side of a processor core and runs alongside instruction execution. It keeps a small byte queue of upcoming instruction code filled by issuing code reads on a simple request/acknowledge memory port. The memory port carries 20-bit addresses and 16-bit data. A consumer, normally the instruction decoder, takes bytes from the head of the queue one at a time through a valid/ready handshake.

All external transfers go through this block. Data operand reads and writes from the execution side share the memory port with the prefetcher. A pending data request takes the bus ahead of any code fetch. A taken branch asserts a flush along with the new target address. The flush empties the queue at once and makes the unit ignore the result of any code read still in flight. Fetching then restarts at the target. When the target is odd, the unit first reads a single byte, so that every later code read is an even-aligned word.

Top module: `ifq_unit`

## Requirements
- R1: While reset is asserted `byte_valid` and `mem_req` are low. After reset the first memory request is a word code read (`mem_wide`=1, `mem_write`=0) at address `RESET_ADDR`, which defaults to 0.
- R2: The queue never holds more than 6 bytes. With the consumer stalled, exactly 6 bytes are fetched after a flush to an even address, and the bus then stays idle.
- R3: A word code read is issued only at an even address and only while at least 2 queue bytes are free. The byte on `mem_rdata[7:0]` comes from the lower address and is delivered before the byte on `mem_rdata[15:8]`.
- R4: When the fetch address is odd, the next code read is a single-byte read (`mem_wide`=0) at that odd address, and its byte is taken from `mem_rdata[15:8]`. It needs at least 1 free byte. The code reads after it are word reads at consecutive even addresses.
- R5: `byte_valid` is high exactly when the queue is non-empty. A byte is removed on a cycle where both `byte_valid` and `byte_ready` are high. Bytes come out in ascending address order, with none lost or repeated.
- R6: A flush empties the queue, so `byte_valid` is low in the next cycle. Fetching restarts at `flush_addr`. The result of a code read in flight during the flush is discarded.
- R7: When the bus is idle and `dreq_valid` is high, the next request issued is the data transfer, even if a code read is also due.
- R8: A data transfer drives `dreq_addr`, `dreq_write` and `dreq_wdata` on the memory port as a word access. `dreq_done` pulses in the acknowledge cycle, and in that cycle `dreq_rdata` carries the word read.
- R9: Once `mem_req` is raised, it stays high with address, size, direction and write data unchanged until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Branch taken: empty the queue and restart fetching |
| flush_addr | input | 20 | New fetch address, sampled with flush |
| byte_valid | output | 1 | Head byte of the queue is available |
| byte_data | output | 8 | Head byte of the queue |
| byte_ready | input | 1 | Consumer takes the head byte |
| dreq_valid | input | 1 | Execution side requests a data transfer; held until done |
| dreq_write | input | 1 | 1 for a write, 0 for a read |
| dreq_addr | input | 20 | Data transfer address |
| dreq_wdata | input | 16 | Data to write |
| dreq_done | output | 1 | Data transfer completes this cycle |
| dreq_rdata | output | 16 | Word read by a data transfer |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_write | output | 1 | Request is a write |
| mem_wide | output | 1 | 1 for a 16-bit access, 0 for a single byte |
| mem_addr | output | 20 | Request address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ack |

## Verification
The hardest situation to reach from the ports is a flush that arrives while a code read is still outstanding. The stale bytes must vanish, even though the memory acknowledges them later. The bench raises the memory latency, lets the queue fill, and then pops two bytes so that exactly one word fetch is issued. It flushes while that request waits for its acknowledge. The first bytes delivered afterwards must belong to the new target and not to the abandoned read. A second hard case is the one-byte-free state, where an even-aligned fetch must be held back. The bench reaches it by stalling the consumer until the queue is full and then releasing single pops, watching the request count after each one.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  localparam int ADDR_W = 20;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ifq_byte_queue.sv
module ifq_byte_queue
  import ifq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [1:0]    push_cnt,
  input  byte_t         push_lo,
  input  byte_t         push_hi,
  input  logic          pop,
  output logic          out_valid,
  output byte_t         out_byte,
  output logic [CW-1:0] free_cnt
);

  logic [PW-1:0] head_q, head_n, tail_q, tail_n, tail_1;
  logic [CW-1:0] count_q, count_n;
  logic          pop_do;
  byte_t         slot_q [DEPTH];
  logic [DEPTH-1:0] wr_en;
  byte_t         wr_val [DEPTH];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    pop_do  = pop && (count_q != '0);
    tail_1  = step(tail_q);
    head_n  = head_q;
    tail_n  = tail_q;
    count_n = count_q;
    if (clear) begin
      head_n  = '0;
      tail_n  = '0;
      count_n = '0;
    end else begin
      if (pop_do) head_n = step(head_q);
      if (push_cnt == 2'd1)      tail_n = tail_1;
      else if (push_cnt == 2'd2) tail_n = step(tail_1);
      count_n = count_q + CW'(push_cnt) - CW'(pop_do);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      count_q <= count_n;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_comb begin
        wr_en[gi]  = !clear &&
                     (((push_cnt != 2'd0) && (tail_q == PW'(gi))) ||
                      ((push_cnt == 2'd2) && (tail_1 == PW'(gi))));
        wr_val[gi] = (tail_q == PW'(gi)) ? push_lo : push_hi;
      end
      always_ff @(posedge clk) begin
        if (wr_en[gi]) slot_q[gi] <= wr_val[gi];
      end
    end
  endgenerate

  assign out_valid = (count_q != '0);
  assign out_byte  = slot_q[head_q];
  assign free_cnt  = CW'(DEPTH) - count_q;

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  assert_push_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && push_cnt != 2'd0) |->
      (int'(count_q) - int'(pop_do) + int'(push_cnt) <= DEPTH));

endmodule

// File: rtl/ifq_bus_ctrl.sv
module ifq_bus_ctrl
  import ifq_pkg::*;
#(
  parameter int    CW         = 3,
  parameter addr_t RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  addr_t         flush_addr,
  input  logic [CW-1:0] free_cnt,
  input  logic          dreq_valid,
  input  logic          dreq_write,
  input  addr_t         dreq_addr,
  input  word_t         dreq_wdata,
  output logic          dreq_done,
  output word_t         dreq_rdata,
  output logic          mem_req,
  output logic          mem_write,
  output logic          mem_wide,
  output addr_t         mem_addr,
  output word_t         mem_wdata,
  input  logic          mem_ack,
  input  word_t         mem_rdata,
  output logic [1:0]    push_cnt,
  output byte_t         push_lo,
  output byte_t         push_hi
);

  logic  busy_q, busy_n, data_q, data_n, wide_q, wide_n, wr_q, wr_n;
  logic  drop_q, drop_n;
  addr_t addr_q, addr_n, fetch_q, fetch_n;
  word_t wdata_q, wdata_n;
  logic  ack_now, issue_data, issue_fetch, fetch_odd;
  logic [CW-1:0] need;

  always_comb begin
    fetch_odd   = fetch_q[0];
    need        = fetch_odd ? CW'(1) : CW'(2);
    ack_now     = busy_q && mem_ack;
    issue_data  = !busy_q && dreq_valid;
    issue_fetch = !busy_q && !dreq_valid && !flush && (free_cnt >= need);

    busy_n  = busy_q;
    data_n  = data_q;
    wide_n  = wide_q;
    wr_n    = wr_q;
    addr_n  = addr_q;
    wdata_n = wdata_q;
    fetch_n = fetch_q;
    drop_n  = drop_q;

    if (ack_now) begin
      busy_n = 1'b0;
      drop_n = 1'b0;
    end
    if (issue_data) begin
      busy_n  = 1'b1;
      data_n  = 1'b1;
      wide_n  = 1'b1;
      wr_n    = dreq_write;
      addr_n  = dreq_addr;
      wdata_n = dreq_wdata;
    end else if (issue_fetch) begin
      busy_n  = 1'b1;
      data_n  = 1'b0;
      wide_n  = !fetch_odd;
      wr_n    = 1'b0;
      addr_n  = fetch_q;
      wdata_n = '0;
      fetch_n = fetch_q + (fetch_odd ? ADDR_W'(1) : ADDR_W'(2));
      drop_n  = 1'b0;
    end
    if (flush) begin
      fetch_n = flush_addr;
      if (busy_q && !data_q && !mem_ack) drop_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      data_q  <= 1'b0;
      wide_q  <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      fetch_q <= RESET_ADDR;
      drop_q  <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      data_q  <= data_n;
      wide_q  <= wide_n;
      wr_q    <= wr_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      fetch_q <= fetch_n;
      drop_q  <= drop_n;
    end
  end

  always_comb begin
    push_cnt = 2'd0;
    if (ack_now && !data_q && !drop_q && !flush) push_cnt = wide_q ? 2'd2 : 2'd1;
    push_lo = wide_q ? mem_rdata[7:0] : mem_rdata[15:8];
    push_hi = mem_rdata[15:8];
  end

  assign dreq_done  = ack_now && data_q;
  assign dreq_rdata = mem_rdata;
  assign mem_req    = busy_q;
  assign mem_write  = wr_q;
  assign mem_wide   = wide_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;

  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wide)
                               && $stable(mem_write) && $stable(mem_wdata)));
  assert_data_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && dreq_valid) |=> (mem_req && data_q));
  assert_word_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !data_q && mem_wide) |-> !mem_addr[0]);
  assert_odd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !data_q && mem_addr[0]) |-> !mem_wide);

endmodule

// File: rtl/ifq_unit.sv
module ifq_unit
  import ifq_pkg::*;
#(
  parameter int    QUEUE_DEPTH = 6,
  parameter addr_t RESET_ADDR  = '0,
  localparam int   CW          = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic [19:0] flush_addr,
  output logic        byte_valid,
  output logic [7:0]  byte_data,
  input  logic        byte_ready,
  input  logic        dreq_valid,
  input  logic        dreq_write,
  input  logic [19:0] dreq_addr,
  input  logic [15:0] dreq_wdata,
  output logic        dreq_done,
  output logic [15:0] dreq_rdata,
  output logic        mem_req,
  output logic        mem_write,
  output logic        mem_wide,
  output logic [19:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata
);

  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic [CW-1:0] free_cnt;
  logic [1:0]    push_cnt;
  byte_t         push_lo, push_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  ifq_bus_ctrl #(.CW(CW), .RESET_ADDR(RESET_ADDR)) u_bus (
    .clk, .rst_n(rst_ni), .flush, .flush_addr, .free_cnt,
    .dreq_valid, .dreq_write, .dreq_addr, .dreq_wdata, .dreq_done, .dreq_rdata,
    .mem_req, .mem_write, .mem_wide, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .push_cnt, .push_lo, .push_hi
  );

  ifq_byte_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
    .clk, .rst_n(rst_ni), .clear(flush), .push_cnt, .push_lo, .push_hi,
    .pop(byte_ready && !flush), .out_valid(byte_valid), .out_byte(byte_data),
    .free_cnt
  );

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    flush |=> !byte_valid);

endmodule

// File: tb/ifq_unit_bench.sv
`timescale 1ns/1ps
module ifq_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, byte_ready = 0, dreq_valid = 0, dreq_write = 0, mem_ack = 0;
  logic [19:0] flush_addr = '0, dreq_addr = '0;
  logic [15:0] dreq_wdata = '0, mem_rdata = '0;
  logic byte_valid, dreq_done, mem_req, mem_write, mem_wide;
  logic [7:0]  byte_data;
  logic [15:0] dreq_rdata, mem_wdata;
  logic [19:0] mem_addr;

  int tests = 0, fails = 0, mem_lat = 1, lat_cnt = 0, req_count = 0, fetched = 0, stable_err = 0;
  logic prev_req = 0;
  logic [19:0] lg_addr [256];
  logic        lg_wide [256];
  logic        lg_write [256];
  logic [15:0] lg_wdata [256];

  always #2 clk = ~clk;

  ifq_unit u_ifq_unit (.*);

  function automatic logic [7:0] fb(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h9};
  endfunction

  // memory model, driven 1 ns after the rising edge
  always begin
    @(posedge clk); #1;
    if (mem_req && prev_req && mem_addr != lg_addr[(req_count-1)%256]) stable_err++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (!prev_req) begin
        lg_addr[req_count%256] = mem_addr;  lg_wide[req_count%256] = mem_wide;
        lg_write[req_count%256] = mem_write; lg_wdata[req_count%256] = mem_wdata;
        req_count++; lat_cnt = 0;
      end
      if (lat_cnt >= mem_lat) begin
        mem_ack = 1'b1;
        mem_rdata = mem_wide ? {fb(mem_addr + 20'd1), fb(mem_addr)} : {fb(mem_addr), 8'h00};
        if (!mem_write) fetched += mem_wide ? 2 : 1;
      end else lat_cnt++;
    end
    prev_req = mem_req;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mem_req) @(negedge clk);
  endtask

  task automatic do_flush(input logic [19:0] a);
    flush = 1; flush_addr = a;
    @(negedge clk);
    flush = 0;
  endtask

  task automatic drain(input int n, input logic [19:0] start, input string rq);
    int k = 0, cyc = 0;
    while (k < n) begin
      @(negedge clk);
      byte_ready = (cyc % 3 != 1);
      if (byte_valid && byte_ready) begin
        chk(byte_data == fb(start + 20'(k)), rq, byte_data, fb(start + 20'(k)));
        k++;
      end
      cyc++;
    end
    @(negedge clk);
    byte_ready = 0;
  endtask

  task automatic pop_one(input logic [19:0] a, input string rq);
    @(negedge clk);
    while (!byte_valid) @(negedge clk);
    byte_ready = 1;
    chk(byte_data == fb(a), rq, byte_data, fb(a));
    @(negedge clk);
    byte_ready = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!byte_valid && !mem_req, "R1 reset outputs", {byte_valid, mem_req}, 0);
    rst_n = 1;
    while (req_count < 1) @(negedge clk);
    chk(lg_addr[0] == 20'h0 && lg_wide[0] && !lg_write[0], "R1 first fetch", lg_addr[0], 0);
  endtask

  task automatic t_stream();
    drain(30, 20'h0, "R5 R3 in-order stream");
  endtask

  task automatic t_space();
    int base;
    repeat (30) @(negedge clk);
    wait_idle();
    do_flush(20'h00100);
    chk(!byte_valid, "R6 empty after flush", byte_valid, 0);
    fetched = 0; base = req_count;
    repeat (40) @(negedge clk);
    chk(fetched == 6, "R2 fills to six", fetched, 6);
    chk(!mem_req && req_count == base + 3, "R2 idle when full", req_count - base, 3);
    pop_one(20'h00100, "R5 pop one");
    repeat (20) @(negedge clk);
    chk(req_count == base + 3, "R3 no word fetch with one free", req_count - base, 3);
    pop_one(20'h00101, "R5 pop two");
    repeat (20) @(negedge clk);
    chk(req_count == base + 4 && fetched == 8, "R3 word fetch with two free", fetched, 8);
    drain(6, 20'h00102, "R3 R5 after refill");
  endtask

  task automatic t_odd();
    int base;
    wait_idle();
    do_flush(20'h00201);
    base = req_count;
    repeat (30) @(negedge clk);
    chk(lg_addr[base%256] == 20'h00201 && !lg_wide[base%256], "R4 single byte first",
        {lg_wide[base%256], lg_addr[base%256]}, 20'h00201);
    chk(lg_addr[(base+1)%256] == 20'h00202 && lg_wide[(base+1)%256], "R4 then even word",
        lg_addr[(base+1)%256], 20'h00202);
    chk(lg_addr[(base+2)%256] == 20'h00204, "R4 next word", lg_addr[(base+2)%256], 20'h00204);
    drain(11, 20'h00201, "R4 odd stream");
  endtask

  task automatic t_inflight();
    mem_lat = 6;
    wait_idle();
    do_flush(20'h00300);
    repeat (60) @(negedge clk);
    pop_one(20'h00300, "R5 pop");
    pop_one(20'h00301, "R5 pop");
    while (!mem_req) @(negedge clk);
    chk(byte_valid, "R5 valid while non-empty", byte_valid, 1);
    do_flush(20'h00480);
    chk(!byte_valid, "R6 empty after flush in flight", byte_valid, 0);
    drain(8, 20'h00480, "R6 stale read discarded");
    mem_lat = 1;
  endtask

  task automatic t_data();
    int base;
    wait_idle();
    mem_lat = 3;
    do_flush(20'h00500);
    while (!mem_req) @(negedge clk);
    base = req_count;
    dreq_valid = 1; dreq_write = 0; dreq_addr = 20'h1234A;
    @(negedge clk);
    while (!dreq_done) @(negedge clk);
    chk(dreq_rdata == {fb(20'h1234B), fb(20'h1234A)}, "R8 read data", dreq_rdata,
        {fb(20'h1234B), fb(20'h1234A)});
    chk(lg_addr[base%256] == 20'h1234A && !lg_write[base%256], "R7 data before fetch",
        lg_addr[base%256], 20'h1234A);
    @(posedge clk); #1;
    dreq_valid = 0;
    @(negedge clk);
    while (!mem_req) @(negedge clk);
    base = req_count;
    dreq_valid = 1; dreq_write = 1; dreq_addr = 20'h0ABC0; dreq_wdata = 16'hBEEF;
    @(negedge clk);
    while (!dreq_done) @(negedge clk);
    chk(lg_write[base%256] && lg_addr[base%256] == 20'h0ABC0 && lg_wdata[base%256] == 16'hBEEF,
        "R8 write on bus", lg_wdata[base%256], 16'hBEEF);
    @(posedge clk); #1;
    dreq_valid = 0; dreq_write = 0;
    drain(8, 20'h00500, "R7 fetch resumes");
    mem_lat = 1;
    chk(stable_err == 0, "R9 request held stable", stable_err, 0);
  endtask

  initial begin
    t_reset();
    t_stream();
    t_space();
    t_odd();
    t_inflight();
    t_data();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule